// File: doc/BRIEF.md
# Four-word burst address generator

This block holds the current access address of a synchronous burst memory. A new base address is taken from the external bus when one of two active-low address strobes is asserted. After that, an active-low advance input steps the two least significant address bits through a four-beat sequence, one step per clock, while the upper address bits stay as loaded.

A static order-select input picks the beat order. When it is low the order is linear: the low bits are the base plus the beat number, modulo four. When it is high the order is interleaved: the low bits are the base XOR the beat number. After the fourth beat the sequence wraps back to the base address. Holding the advance input high suspends the burst in place.

The controller strobe always loads. The processor strobe loads only while chip enable is low. Both outputs are registered, and the beat index is also given as an output.

Top module: `burst_addr_gen`

## Requirements
- R1: While synchronous reset is high, on each rising edge the address output and the beat index are set to zero.
- R2: A low controller strobe (`load_ctrl_n`) at a rising edge loads `ext_addr` into `cur_addr` and sets `beat_idx` to 0, whatever the levels of chip enable and advance.
- R3: A low processor strobe (`load_proc_n`) loads the address only when `chip_en_n` is also low. While `chip_en_n` is high it has no effect, and the edge acts as if no strobe were asserted.
- R4: With `order_sel` low (linear), after beat k the low two address bits equal (base + k) mod 4. For example, base 01 gives 01, 10, 11, 00.
- R5: With `order_sel` high (interleaved), after beat k the low two address bits equal base XOR k. For example, base 01 gives 01, 00, 11, 10.
- R6: With no load active and `advance_n` high, `cur_addr` and `beat_idx` keep their values (the burst is suspended).
- R7: With no load active and `advance_n` low, `beat_idx` increments by one per clock. From beat 3 it wraps to 0, and the address returns to the base.
- R8: Only address bits [1:0] change during a burst. Bits above them keep the loaded value until the next load.
- R9: A load on the same edge as an active advance takes priority: the new address is captured and `beat_idx` becomes 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_addr | input | ADDR_W | External address bus |
| load_ctrl_n | input | 1 | Controller address strobe, active low, not gated |
| load_proc_n | input | 1 | Processor address strobe, active low, gated by chip enable |
| chip_en_n | input | 1 | Chip enable, active low |
| advance_n | input | 1 | Burst advance, active low |
| order_sel | input | 1 | Beat order: 0 linear, 1 interleaved; static |
| cur_addr | output | ADDR_W | Current access address |
| beat_idx | output | 2 | Beat number within the current burst, 0 to 3 |

## Verification
Every result of this block is due exactly one rising edge after the inputs that cause it: a load, a step, a hold or a reset, each decided at one edge, is visible on `cur_addr` and `beat_idx` after that edge and not before. The bench drives the strobes, the advance input and the bus on the falling edge. It then advances its behavioural model by one step for those inputs and compares both outputs at the next falling edge, half a period after the edge that acts on them. `order_sel` is changed only while the beat index is 0, which keeps to its static-input rule.

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;

    localparam int LOW_W  = 2;
    localparam int BEAT_W = 2;

    typedef logic [BEAT_W-1:0] beat_t;
    typedef logic [LOW_W-1:0]  low_t;

    typedef enum logic [1:0] {
        OP_HOLD = 2'd0,
        OP_LOAD = 2'd1,
        OP_STEP = 2'd2
    } burst_op_e;

    typedef struct packed {
        beat_t cur;
        beat_t nxt;
    } beat_pair_t;

    // Low address bits for a given beat under the selected order.
    function automatic low_t seq_low(input low_t base, input beat_t beat, input logic interleave);
        low_t r;
        if (interleave) r = base ^ beat;
        else            r = base + beat;
        return r;
    endfunction

endpackage

// File: rtl/burst_strobe_decode.sv
module burst_strobe_decode
    import burst_addr_pkg::*;
(
    input  logic      load_ctrl_n,
    input  logic      load_proc_n,
    input  logic      chip_en_n,
    input  logic      advance_n,
    output burst_op_e op
);
    logic proc_gated;

    always_comb begin
        proc_gated = !load_proc_n && !chip_en_n;
        if (!load_ctrl_n || proc_gated) op = OP_LOAD;
        else if (!advance_n)            op = OP_STEP;
        else                            op = OP_HOLD;
    end
endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr
    import burst_addr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  burst_op_e  op,
    output beat_pair_t beat
);
    beat_t beat_q;

    always_comb begin
        beat.cur = beat_q;
        beat.nxt = beat_q + beat_t'(1);
    end

    always_ff @(posedge clk) begin
        if (rst)                beat_q <= '0;
        else if (op == OP_LOAD) beat_q <= '0;
        else if (op == OP_STEP) beat_q <= beat.nxt;
    end

    AST_BEAT_WRAP: assert property (@(posedge clk) disable iff (rst)
        (op == OP_STEP && beat_q == beat_t'(3)) |=> beat_q == '0); // R7
endmodule

// File: rtl/burst_addr_hold.sv
module burst_addr_hold
    import burst_addr_pkg::*;
#(
    parameter int ADDR_W = 18
) (
    input  logic              clk,
    input  logic              rst,
    input  burst_op_e         op,
    input  beat_pair_t        beat,
    input  logic              order_sel,
    input  logic [ADDR_W-1:0] ext_addr,
    output logic [ADDR_W-1:0] cur_addr
);
    localparam int UPPER_W = ADDR_W - LOW_W;

    low_t base_q;
    low_t low_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            low_q  <= '0;
        end else if (op == OP_LOAD) begin
            base_q <= ext_addr[LOW_W-1:0];
            low_q  <= ext_addr[LOW_W-1:0];
        end else if (op == OP_STEP) begin
            low_q  <= seq_low(base_q, beat.nxt, order_sel);
        end
    end

    generate
        if (UPPER_W > 0) begin : g_upper
            logic [UPPER_W-1:0] upper_q;
            always_ff @(posedge clk) begin
                if (rst)                upper_q <= '0;
                else if (op == OP_LOAD) upper_q <= ext_addr[ADDR_W-1:LOW_W];
            end
            assign cur_addr = {upper_q, low_q};
        end else begin : g_low_only
            assign cur_addr = low_q;
        end
    endgenerate

    // Low bits track the beat counter held in the separate counter block.
    AST_LOW_FOLLOWS_ORDER: assert property (@(posedge clk) disable iff (rst)
        low_q == seq_low(base_q, beat.cur, order_sel)); // R4 R5
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import burst_addr_pkg::*;
#(
    parameter int ADDR_W = 18
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] ext_addr,
    input  logic              load_ctrl_n,
    input  logic              load_proc_n,
    input  logic              chip_en_n,
    input  logic              advance_n,
    input  logic              order_sel,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [1:0]        beat_idx
);
    burst_op_e  op;
    beat_pair_t beat;

    burst_strobe_decode u_decode (
        .load_ctrl_n (load_ctrl_n),
        .load_proc_n (load_proc_n),
        .chip_en_n   (chip_en_n),
        .advance_n   (advance_n),
        .op          (op)
    );

    burst_beat_ctr u_beat (
        .clk  (clk),
        .rst  (rst),
        .op   (op),
        .beat (beat)
    );

    burst_addr_hold #(.ADDR_W(ADDR_W)) u_hold (
        .clk       (clk),
        .rst       (rst),
        .op        (op),
        .beat      (beat),
        .order_sel (order_sel),
        .ext_addr  (ext_addr),
        .cur_addr  (cur_addr)
    );

    assign beat_idx = beat.cur;

    AST_CTRL_LOAD: assert property (@(posedge clk) disable iff (rst)
        !load_ctrl_n |=> (cur_addr == $past(ext_addr)) && (beat_idx == 2'd0)); // R2

    AST_PROC_GATED: assert property (@(posedge clk) disable iff (rst)
        (load_ctrl_n && !load_proc_n && chip_en_n && advance_n) |=> $stable(cur_addr)); // R3

    AST_SUSPEND_HOLD: assert property (@(posedge clk) disable iff (rst)
        (load_ctrl_n && (load_proc_n || chip_en_n) && advance_n)
        |=> ($stable(cur_addr) && $stable(beat_idx))); // R6

    AST_UPPER_STABLE: assert property (@(posedge clk) disable iff (rst)
        (load_ctrl_n && (load_proc_n || chip_en_n))
        |=> (cur_addr[ADDR_W-1:LOW_W] == $past(cur_addr[ADDR_W-1:LOW_W]))); // R8

    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (rst)
        (!load_proc_n && !chip_en_n && !advance_n) |=> (beat_idx == 2'd0)); // R9
endmodule

// File: tb/burst_addr_gen_bench.sv
`timescale 1ns/1ps
module burst_addr_gen_bench;
    localparam int ADDR_W = 18;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [ADDR_W-1:0] ext_addr = '0;
    logic              load_ctrl_n = 1'b1;
    logic              load_proc_n = 1'b1;
    logic              chip_en_n = 1'b1;
    logic              advance_n = 1'b1;
    logic              order_sel = 1'b0;
    logic [ADDR_W-1:0] cur_addr;
    logic [1:0]        beat_idx;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // behavioural reference state
    int m_upper = 0;
    int m_base  = 0;
    int m_beat  = 0;

    always #4 clk = ~clk;

    burst_addr_gen #(.ADDR_W(ADDR_W)) u_burst_addr_gen (
        .clk(clk), .rst(rst), .ext_addr(ext_addr),
        .load_ctrl_n(load_ctrl_n), .load_proc_n(load_proc_n),
        .chip_en_n(chip_en_n), .advance_n(advance_n), .order_sel(order_sel),
        .cur_addr(cur_addr), .beat_idx(beat_idx)
    );

    function automatic int exp_addr();
        int low;
        if (order_sel) low = m_base ^ m_beat;
        else           low = (m_base + m_beat) % 4;
        return m_upper * 4 + low;
    endfunction

    task automatic compare(input string tag);
        int ea;
        ea = exp_addr();
        checks++;
        if (int'(cur_addr) != ea) begin
            errors++;
            $display("FAIL %s cur_addr actual %h expected %h", tag, cur_addr, ea[ADDR_W-1:0]);
        end
        checks++;
        if (int'(beat_idx) != m_beat) begin
            errors++;
            $display("FAIL %s beat_idx actual %0d expected %0d", tag, beat_idx, m_beat);
        end
    endtask

    // Called at a falling edge: drive, model one edge, compare at next falling edge.
    task automatic cyc(input logic c_n, input logic p_n, input logic e_n, input logic a_n,
                       input logic [ADDR_W-1:0] a, input string tag);
        load_ctrl_n = c_n;
        load_proc_n = p_n;
        chip_en_n   = e_n;
        advance_n   = a_n;
        ext_addr    = a;
        if (!c_n || (!p_n && !e_n)) begin
            m_upper = int'(a) / 4;
            m_base  = int'(a) % 4;
            m_beat  = 0;
        end else if (!a_n) begin
            m_beat = (m_beat + 1) % 4;
        end
        @(negedge clk);
        compare(tag);
    endtask

    initial begin
        #20000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        ext_addr = 18'h3FFFF;
        advance_n = 1'b0;
        @(negedge clk);
        compare("R1 reset state");
        rst = 1'b0;

        // R2: controller strobe loads while chip enable is high
        cyc(1'b0, 1'b1, 1'b1, 1'b1, 18'h1A5C1, "R2 ctrl load");
        // R4 R8 R7: linear from base 01, wrap after four beats
        for (int i = 0; i < 5; i++) cyc(1'b1, 1'b1, 1'b1, 1'b0, 18'h00000, "R4 R7 R8 linear step");
        // R6: suspend
        cyc(1'b1, 1'b1, 1'b0, 1'b1, 18'h2FFFF, "R6 suspend");
        cyc(1'b1, 1'b1, 1'b0, 1'b1, 18'h2FFFF, "R6 suspend");
        cyc(1'b1, 1'b1, 1'b0, 1'b0, 18'h2FFFF, "R4 step after suspend");
        // R3: processor strobe ignored with chip enable high, advance acts
        cyc(1'b1, 1'b0, 1'b1, 1'b0, 18'h0BEE2, "R3 gated proc strobe");
        cyc(1'b1, 1'b0, 1'b1, 1'b1, 18'h0BEE2, "R3 gated proc strobe hold");
        // R3 R9: processor strobe with chip enable low, advance low too
        cyc(1'b1, 1'b0, 1'b0, 1'b0, 18'h24443, "R3 R9 proc load wins");
        cyc(1'b1, 1'b1, 1'b0, 1'b0, 18'h00000, "R4 linear from 11");
        // switch to interleaved while at beat 0, via a load in the same edge
        cyc(1'b0, 1'b1, 1'b1, 1'b1, 18'h15551, "R2 reload");
        order_sel = 1'b1;
        cyc(1'b1, 1'b1, 1'b1, 1'b1, 18'h00000, "R6 hold at mode change");
        for (int i = 0; i < 5; i++) cyc(1'b1, 1'b1, 1'b1, 1'b0, 18'h3AAAA, "R5 R7 R8 interleave step");
        // R9: controller load mid burst with advance low
        cyc(1'b0, 1'b1, 1'b1, 1'b0, 18'h09993, "R9 ctrl load over advance");
        for (int i = 0; i < 4; i++) cyc(1'b1, 1'b1, 1'b0, 1'b0, 18'h00000, "R5 R7 interleave from 11");
        cyc(1'b1, 1'b1, 1'b1, 1'b0, 18'h00000, "R5 step");
        // R1: reset mid burst
        rst = 1'b1;
        m_upper = 0; m_base = 0; m_beat = 0;
        @(negedge clk);
        compare("R1 reset mid burst");

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule